// File: doc/BRIEF.md
# Serial Control Register for an Audio Selector

This block is the digital control front end of a mixed-signal audio selector. A host shifts a 24-bit control word into it one bit per rising edge of a serial clock, least-numbered bit (D0) first, and then raises a separate latch strobe. On that strobe the block checks the frame length and a two-bit chip address carried in the last two bits. Only a well-formed frame addressed to chip 0 changes the registered control outputs. Every other frame leaves them untouched.

The word holds several fields: an input selector with three mute codes and five stereo pairs, a gain step, a mode code whose top bit enables the key-controller path, eight open-collector sink enables, two tri-state port controls with low, open and high states, and a microphone mute flag. The serial clock, data and latch come in asynchronously. Each is synchronized to the system clock, and the block acts on the rising edges it detects after synchronization. A synchronous reset loads the power-on settings.

Top module: `serial_ctrl_reg`

## Requirements
- R1: A serial bit is taken on each detected rising edge of `ser_clk_i` and becomes frame bit Dn, where n is the number of serial clock edges since the last latch rise. A frame is D0..D23, with D0 sent first.
- R2: On a latch rise the frame is committed only if exactly 24 serial clock edges came since the previous latch rise and D22 = D23 = 0. Otherwise all outputs keep their values. Every latch rise clears the bit count, so the next frame starts fresh.
- R3: The input code is {D0,D1,D2}, with D0 as MSB. Codes 0, 1 and 2 give `in_mute_o`=1 and `in_sel_o`=0. Codes 3 to 7 give `in_mute_o`=0 and `in_sel_o` = code-3 (0=A .. 4=E).
- R4: The gain code is {D3,D4,D5}, with D3 as MSB. `gain_db_o` = 6 + 2*code, giving 6..20.
- R5: The mode code is {D6,D7,D8}, with D6 as MSB, and appears on `mode_o`. `key_on_o` is 1 exactly when D6 is 1 (codes 4..7). Code 0 is mute and code 2 is through.
- R6: `oc_sink_o[k]` drives open-collector port k+1 and takes frame bit D(16-k), so D16 drives port 1 and D9 drives port 8. A value of 1 means the sink is on.
- R7: Tri-state port 0 uses pair {D17,D18} and port 1 uses pair {D19,D20}. Pair 00 gives drive=1, level=0. Pair 11 gives drive=1, level=1. Pairs 01 and 10 give drive=0 (open). The results appear on `ts_drive_o[i]` and `ts_level_o[i]`.
- R8: `mic_mute_o` equals D21. A value of 1 mutes the microphone.
- R9: While `rst` is high, and after it falls, the outputs are: all sinks off, both tri-state ports driving low, input A (`in_mute_o`=0, `in_sel_o`=0), gain 6 dB, mode 2 (through), `key_on_o`=0, mic mute 0.
- R10: While the synchronized latch is high, serial clock edges still count, but each shifted bit is forced to 0, whatever the value of `ser_data_i`.
- R11: Outputs change only in the cycle after a detected latch rise. A commit is visible within 4 system clock cycles after `latch_i` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial bit clock (asynchronous) |
| ser_data_i | input | 1 | Serial data (asynchronous) |
| latch_i | input | 1 | Commit strobe (asynchronous) |
| oc_sink_o | output | 8 | Open-collector sink enables, bit k = port k+1 |
| ts_drive_o | output | 2 | Tri-state drive enables, 0 = open |
| ts_level_o | output | 2 | Tri-state driven levels |
| in_mute_o | output | 1 | Input muted |
| in_sel_o | output | 3 | Selected stereo pair, 0=A .. 4=E |
| gain_db_o | output | 5 | Gain in dB |
| mode_o | output | 3 | Mode code |
| key_on_o | output | 1 | Key-controller path enabled |
| mic_mute_o | output | 1 | Microphone mute |

## Verification
A wrong bit count or a stale shift register does not show until the next latch rise. It then shows as a frame that is wrongly committed or wrongly rejected, or as fields shifted by one position, visible a few cycles after the strobe. Length, address and masking faults therefore need frames whose outputs differ from the values already held. Each test first loads a contrasting word, so that a dropped or stray commit changes some output. Field-mapping faults appear at once on the next good frame as swapped port bits or wrong code mappings.

// File: rtl/selctl_pkg.sv
package selctl_pkg;

  localparam int FRAME_BITS = 24;
  localparam int IN_POS     = 0;
  localparam int GAIN_POS   = 3;
  localparam int MODE_POS   = 6;
  localparam int OC_POS     = 9;
  localparam int OC_PORTS   = 8;
  localparam int TS_POS     = 17;
  localparam int TS_PORTS   = 2;
  localparam int MIC_POS    = 21;
  localparam int ADDR_POS   = 22;
  localparam int MUTE_CODES = 3;

  localparam logic [2:0] MODE_THROUGH = 3'b010;

  typedef struct packed {
    logic                in_mute;
    logic [2:0]          in_sel;
    logic [2:0]          gain_code;
    logic [2:0]          mode_code;
    logic [OC_PORTS-1:0] oc_sink;
    logic [TS_PORTS-1:0] ts_drive;
    logic [TS_PORTS-1:0] ts_level;
    logic                mic_mute;
  } ctrl_t;

  function automatic ctrl_t power_on_ctrl();
    ctrl_t c;
    c.in_mute   = 1'b0;
    c.in_sel    = 3'd0;
    c.gain_code = 3'd0;
    c.mode_code = MODE_THROUGH;
    c.oc_sink   = '0;
    c.ts_drive  = '1;
    c.ts_level  = '0;
    c.mic_mute  = 1'b0;
    return c;
  endfunction

endpackage

// File: rtl/in_sync.sv
module in_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);

  logic [STAGES-1:0][W-1:0] chain;
  logic [W-1:0]             prev;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= chain[STAGES-1];
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int FRAME_BITS = 24,
  localparam int CNT_W     = $clog2(FRAME_BITS + 2)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bit_edge,
  input  logic                  latch_edge,
  input  logic                  latch_lvl,
  input  logic                  data_lvl,
  output logic [FRAME_BITS-1:0] frame,
  output logic [CNT_W-1:0]      bit_cnt
);

  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_BITS + 1);

  logic in_bit;
  assign in_bit = data_lvl & ~latch_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame   <= '0;
      bit_cnt <= '0;
    end else if (latch_edge) begin
      bit_cnt <= '0;
    end else if (bit_edge) begin
      frame <= {in_bit, frame[FRAME_BITS-1:1]};
      if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/field_decode.sv
module field_decode
  import selctl_pkg::*;
(
  input  logic [FRAME_BITS-1:0] frame,
  output ctrl_t                 ctrl
);

  logic [2:0] in_code;

  assign in_code = {frame[IN_POS], frame[IN_POS+1], frame[IN_POS+2]};

  always_comb begin
    ctrl.in_mute   = (in_code < 3'(MUTE_CODES));
    ctrl.in_sel    = ctrl.in_mute ? 3'd0 : in_code - 3'(MUTE_CODES);
    ctrl.gain_code = {frame[GAIN_POS], frame[GAIN_POS+1], frame[GAIN_POS+2]};
    ctrl.mode_code = {frame[MODE_POS], frame[MODE_POS+1], frame[MODE_POS+2]};
    ctrl.mic_mute  = frame[MIC_POS];
  end

  generate
    for (genvar k = 0; k < OC_PORTS; k++) begin : g_oc
      assign ctrl.oc_sink[k] = frame[OC_POS + OC_PORTS - 1 - k];
    end
    for (genvar t = 0; t < TS_PORTS; t++) begin : g_ts
      logic [1:0] pair;
      assign pair = {frame[TS_POS + 2*t], frame[TS_POS + 2*t + 1]};
      assign ctrl.ts_drive[t] = (pair == 2'b00) || (pair == 2'b11);
      assign ctrl.ts_level[t] = (pair == 2'b11);
    end
  endgenerate

endmodule

// File: rtl/serial_ctrl_reg.sv
module serial_ctrl_reg
  import selctl_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int GAIN_BASE_DB = 6,
  parameter int GAIN_STEP_DB = 2,
  localparam int GAIN_W      = $clog2(GAIN_BASE_DB + 7*GAIN_STEP_DB + 1),
  localparam int CNT_W       = $clog2(FRAME_BITS + 2)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_clk_i,
  input  logic                ser_data_i,
  input  logic                latch_i,
  output logic [OC_PORTS-1:0] oc_sink_o,
  output logic [TS_PORTS-1:0] ts_drive_o,
  output logic [TS_PORTS-1:0] ts_level_o,
  output logic                in_mute_o,
  output logic [2:0]          in_sel_o,
  output logic [GAIN_W-1:0]   gain_db_o,
  output logic [2:0]          mode_o,
  output logic                key_on_o,
  output logic                mic_mute_o
);

  logic [2:0]            s_lvl, s_rise;
  logic                  latch_rise;
  logic [FRAME_BITS-1:0] frame;
  logic [CNT_W-1:0]      bit_cnt;
  ctrl_t                 dec, ctrl_q;
  logic [GAIN_W-1:0]     gain_q;
  logic                  commit;

  in_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({latch_i, ser_data_i, ser_clk_i}),
    .lvl (s_lvl),
    .rise(s_rise)
  );

  assign latch_rise = s_rise[2];

  frame_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .bit_edge  (s_rise[0]),
    .latch_edge(latch_rise),
    .latch_lvl (s_lvl[2]),
    .data_lvl  (s_lvl[1]),
    .frame     (frame),
    .bit_cnt   (bit_cnt)
  );

  field_decode u_dec (
    .frame(frame),
    .ctrl (dec)
  );

  assign commit = latch_rise
               && (bit_cnt == CNT_W'(FRAME_BITS))
               && (frame[ADDR_POS+1:ADDR_POS] == 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= power_on_ctrl();
      gain_q <= GAIN_W'(GAIN_BASE_DB);
    end else if (commit) begin
      ctrl_q <= dec;
      gain_q <= GAIN_W'(GAIN_BASE_DB + GAIN_STEP_DB * int'(dec.gain_code));
    end
  end

  assign oc_sink_o  = ctrl_q.oc_sink;
  assign ts_drive_o = ctrl_q.ts_drive;
  assign ts_level_o = ctrl_q.ts_level;
  assign in_mute_o  = ctrl_q.in_mute;
  assign in_sel_o   = ctrl_q.in_sel;
  assign gain_db_o  = gain_q;
  assign mode_o     = ctrl_q.mode_code;
  assign key_on_o   = ctrl_q.mode_code[2];
  assign mic_mute_o = ctrl_q.mic_mute;

endmodule

// File: rtl/selctl_chk.sv
module selctl_chk #(
  parameter int FRAME_BITS   = 24,
  parameter int GAIN_BASE_DB = 6,
  parameter int GAIN_STEP_DB = 2,
  parameter int GAIN_W       = 5,
  parameter int CNT_W        = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              latch_rise,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [7:0]        oc_sink,
  input logic [1:0]        ts_drive,
  input logic [1:0]        ts_level,
  input logic              in_mute,
  input logic [2:0]        in_sel,
  input logic [GAIN_W-1:0] gain_db,
  input logic [2:0]        mode,
  input logic              mic_mute
);

  AST_HOLD_WITHOUT_LATCH: assert property (@(posedge clk) disable iff (rst)
    !$past(latch_rise) |-> $stable({oc_sink, ts_drive, ts_level, in_mute, in_sel, gain_db, mode, mic_mute})) // R11
    else $error("outputs moved without a latch rise");

  AST_COUNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
    latch_rise |=> (bit_cnt == '0)) // R2
    else $error("bit count not cleared by latch");

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    int'(bit_cnt) <= FRAME_BITS + 1) // R1
    else $error("bit count beyond saturation");

  AST_MUTE_SEL_ZERO: assert property (@(posedge clk) disable iff (rst)
    in_mute |-> (in_sel == 3'd0)) // R3
    else $error("muted input with nonzero select");

  AST_GAIN_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (int'(gain_db) >= GAIN_BASE_DB) && (int'(gain_db) <= GAIN_BASE_DB + 7*GAIN_STEP_DB)
    && (((int'(gain_db) - GAIN_BASE_DB) % GAIN_STEP_DB) == 0)) // R4
    else $error("gain off the step grid");

endmodule

bind serial_ctrl_reg selctl_chk #(
  .FRAME_BITS  (selctl_pkg::FRAME_BITS),
  .GAIN_BASE_DB(GAIN_BASE_DB),
  .GAIN_STEP_DB(GAIN_STEP_DB),
  .GAIN_W      (GAIN_W),
  .CNT_W       (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .latch_rise(latch_rise),
  .bit_cnt   (bit_cnt),
  .oc_sink   (oc_sink_o),
  .ts_drive  (ts_drive_o),
  .ts_level  (ts_level_o),
  .in_mute   (in_mute_o),
  .in_sel    (in_sel_o),
  .gain_db   (gain_db_o),
  .mode      (mode_o),
  .mic_mute  (mic_mute_o)
);

// File: tb/test_serial_ctrl_reg.sv
module test_serial_ctrl_reg;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, latch = 1'b0;
  logic [7:0] oc_sink;
  logic [1:0] ts_drive, ts_level;
  logic       in_mute, key_on, mic_mute;
  logic [2:0] in_sel, mode;
  logic [4:0] gain_db;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] e_oc;
  logic [1:0] e_drv, e_lvl;
  logic       e_mute, e_key, e_mic;
  logic [2:0] e_sel, e_mode;
  logic [4:0] e_gain;

  always #2 clk = ~clk;

  serial_ctrl_reg i_serial_ctrl_reg (
    .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .ser_data_i(ser_data), .latch_i(latch),
    .oc_sink_o(oc_sink), .ts_drive_o(ts_drive), .ts_level_o(ts_level),
    .in_mute_o(in_mute), .in_sel_o(in_sel), .gain_db_o(gain_db),
    .mode_o(mode), .key_on_o(key_on), .mic_mute_o(mic_mute)
  );

  function automatic logic [23:0] mk(input logic [2:0] in_c, input logic [2:0] g,
                                     input logic [2:0] m, input logic [7:0] oc,
                                     input logic [1:0] t0, input logic [1:0] t1,
                                     input logic mic, input logic [1:0] addr);
    logic [23:0] f;
    f[0] = in_c[2]; f[1] = in_c[1]; f[2] = in_c[0];
    f[3] = g[2];    f[4] = g[1];    f[5] = g[0];
    f[6] = m[2];    f[7] = m[1];    f[8] = m[0];
    for (int p = 1; p <= 8; p++) f[17-p] = oc[p-1];
    f[17] = t0[1]; f[18] = t0[0];
    f[19] = t1[1]; f[20] = t1[0];
    f[21] = mic;
    f[22] = addr[1]; f[23] = addr[0];
    return f;
  endfunction

  task automatic expect_frame(input logic [23:0] f);
    logic [2:0] c;
    c      = {f[0], f[1], f[2]};
    e_mute = (c < 3);
    e_sel  = e_mute ? 3'd0 : c - 3'd3;
    e_gain = 5'd6 + 5'd2 * {2'b00, f[3], f[4], f[5]};
    e_mode = {f[6], f[7], f[8]};
    e_key  = f[6];
    for (int k = 0; k < 8; k++) e_oc[k] = f[16-k];
    for (int t = 0; t < 2; t++) begin
      e_drv[t] = (f[17+2*t] == f[18+2*t]);
      e_lvl[t] = f[17+2*t] & f[18+2*t];
    end
    e_mic = f[21];
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "oc_sink",  oc_sink,  e_oc);
    chk(req, "ts_drive", ts_drive, e_drv);
    chk(req, "ts_level", ts_level, e_lvl);
    chk(req, "in_mute",  in_mute,  e_mute);
    chk(req, "in_sel",   in_sel,   e_sel);
    chk(req, "gain_db",  gain_db,  e_gain);
    chk(req, "mode",     mode,     e_mode);
    chk(req, "key_on",   key_on,   e_key);
    chk(req, "mic_mute", mic_mute, e_mic);
  endtask

  task automatic pulse_bit(input logic b);
    @(negedge clk); ser_data = b;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (3) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  // leaves latch high; outputs sampled 4 cycles after the latch rise (R11)
  task automatic send_frame(input logic [23:0] f, input int nbits);
    @(negedge clk); latch = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) pulse_bit(i < 24 ? f[i] : 1'b0);
    @(negedge clk); ser_data = 1'b0;
    repeat (3) @(negedge clk);
    latch = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    expect_frame(mk(3'd3, 3'd0, 3'd2, 8'h00, 2'b00, 2'b00, 1'b0, 2'b00));
    check_all("R9");
  endtask

  task automatic t_full_frame();
    logic [23:0] f;
    f = mk(3'd5, 3'd5, 3'd6, 8'h2D, 2'b11, 2'b01, 1'b1, 2'b00);
    send_frame(f, 24);
    expect_frame(f);
    check_all("R1/R6/R8/R11");
  endtask

  task automatic t_input_codes();
    for (int c = 0; c < 8; c++) begin
      logic [23:0] f;
      f = mk(3'(c), 3'd1, 3'd2, 8'h01, 2'b00, 2'b11, 1'b0, 2'b00);
      send_frame(f, 24);
      expect_frame(f);
      chk("R3", "in_mute", in_mute, e_mute);
      chk("R3", "in_sel",  in_sel,  e_sel);
    end
  endtask

  task automatic t_gain_steps();
    for (int g = 0; g < 8; g++) begin
      send_frame(mk(3'd4, 3'(g), 3'd2, 8'h00, 2'b00, 2'b00, 1'b0, 2'b00), 24);
      chk("R4", "gain_db", gain_db, 6 + 2*g);
    end
  endtask

  task automatic t_modes();
    for (int m = 0; m < 8; m++) begin
      send_frame(mk(3'd3, 3'd0, 3'(m), 8'h00, 2'b00, 2'b00, 1'b0, 2'b00), 24);
      chk("R5", "mode", mode, m);
      chk("R5", "key_on", key_on, (m >= 4) ? 1 : 0);
    end
  endtask

  task automatic t_ports();
    for (int p = 0; p < 8; p++) begin
      send_frame(mk(3'd3, 3'd0, 3'd2, 8'(1 << p), 2'b00, 2'b00, 1'b0, 2'b00), 24);
      chk("R6", "oc_sink one-hot", oc_sink, 1 << p);
    end
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        logic [23:0] f;
        f = mk(3'd3, 3'd0, 3'd2, 8'h00, 2'(a), 2'(b), 1'b0, 2'b00);
        send_frame(f, 24);
        expect_frame(f);
        chk("R7", "ts_drive", ts_drive, e_drv);
        chk("R7", "ts_level", ts_level, e_lvl);
      end
    end
  endtask

  task automatic t_addr_reject();
    logic [23:0] good;
    good = mk(3'd7, 3'd7, 3'd1, 8'hC3, 2'b11, 2'b11, 1'b1, 2'b00);
    send_frame(good, 24);
    expect_frame(good);
    for (int a = 1; a < 4; a++) begin
      send_frame(mk(3'd0, 3'd0, 3'd0, 8'h00, 2'b01, 2'b10, 1'b0, 2'(a)), 24);
      check_all("R2 address");
    end
  endtask

  task automatic t_bad_length();
    logic [23:0] f;
    f = mk(3'd0, 3'd3, 3'd0, 8'h5A, 2'b10, 2'b00, 1'b0, 2'b00);
    send_frame(f, 23);
    check_all("R2 short");
    send_frame(f, 25);
    check_all("R2 long");
    send_frame(f, 24);
    expect_frame(f);
    check_all("R2 recover");
  endtask

  task automatic t_latch_mask();
    send_frame(mk(3'd6, 3'd6, 3'd7, 8'hFF, 2'b11, 2'b11, 1'b1, 2'b00), 24);
    @(negedge clk); latch = 1'b0;
    repeat (4) @(negedge clk);
    latch = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 24; i++) pulse_bit(1'b1);
    @(negedge clk); ser_data = 1'b0; latch = 1'b0;
    repeat (4) @(negedge clk);
    latch = 1'b1;
    repeat (4) @(negedge clk);
    expect_frame(24'h0);
    check_all("R10");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_full_frame();
    t_input_codes();
    t_gain_steps();
    t_modes();
    t_ports();
    t_addr_reject();
    t_bad_length();
    t_latch_mask();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R11 watchdog: actual=timeout expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule